// File: doc/BRIEF.md
# Nibble-Coded Command Register Port

This block is the command side of a slave peripheral's external bus. An external master selects it by driving the three-bit port selector to `3'b100` and then pushes bytes on an 8-bit data input, one per strobe. The top bit of each byte marks it as an address byte or a data byte. An address byte names one of 64 registers and says whether the master wants to read it or write it. A write delivers its value as two data bytes, upper nibble first, and each of those bytes carries four payload bits.

After every accepted byte the block pulls its `ready` output low for a fixed number of cycles. The master must wait for `ready` to return high before it sends the next byte. A read request answers by raising `data_irq` with the register value on `dout`. It holds both until the master acknowledges. A write address stays armed after each completed nibble pair, so a stream of pairs lands on the same register, which is how multi-byte ports such as the descriptor port at 0x30 are fed. Three registers form a window onto a 16-bit extended address space: 0x3A holds the low address byte, 0x3B holds the high address byte, and 0x3C reads or writes the location they point at. The model backs the window with `EXT_DEPTH` bytes.

Top module: `cmd_nibble_port`

## Requirements
- R1: A byte is accepted only on a clock edge where `wr_stb` is 1, `port_sel` equals 3'b100 and `ready` is 1. Any other strobe has no effect on registers or on `ready`.
- R2: An accepted byte with bit 7 = 1 is an address byte. Bit 6 = 1 requests a read and bit 6 = 0 arms a write. Bits 5:0 give the register address.
- R3: An accepted byte with bit 7 = 0 is a data byte. Only bits 3:0 carry payload and bits 6:4 are ignored. The first data byte after a write address supplies bits 7:4 of the value and the second supplies bits 3:0. The register is updated when the second data byte arrives.
- R4: An address byte that arrives while only the upper nibble is held discards that nibble and the earlier address, so the earlier register keeps its old value.
- R5: After each accepted byte, `ready` is 0 for exactly `READY_LAT` clock cycles and then returns to 1, unless a read is pending.
- R6: After a read address byte, `data_irq` rises `READY_LAT` cycles after acceptance with the register value on `dout`. It stays high with `ready` low until a cycle with `rd_ack` = 1. It is then 0 on the next cycle. When `data_irq` is 0, `dout` is 0.
- R7: After a completed nibble pair the write address stays armed. Each further pair writes the same register, and the last pair written is the value read back.
- R8: A data byte that arrives when no write address is armed (after reset, or after a read request) is ignored.
- R9: A write to 0x3C stores the byte at extended address {reg 0x3B, reg 0x3A}. A read of 0x3C returns the byte stored there. A read of 0x3A or 0x3B returns the address byte last written to it.
- R10: An extended address at or above `EXT_DEPTH` hits nothing: a write there changes no location, and a read there returns 0x00.
- R11: After reset `ready` is 1, `data_irq` is 0, `dout` is 0x00, and every register and extended location reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_sel | input | 3 | Port selector; 3'b100 addresses this block |
| wr_stb | input | 1 | Byte write qualifier from the master |
| rd_ack | input | 1 | Master acknowledges the presented read data |
| din | input | 8 | Byte from the master |
| dout | output | 8 | Read data, valid while `data_irq` is 1 |
| ready | output | 1 | High when the next byte may be sent |
| data_irq | output | 1 | Read data waiting on `dout` |

## Verification
A stale nibble flag or a write address left armed shows up at the ports as a wrong value on a later read-back. The error appears within a few bytes of the faulty step, so the bench reads back right after each abort, ignore and window sequence. A wrong busy counter changes how long `ready` stays low. The bench counts those cycles on the very next byte. A lost or stuck read-pending state shows as `data_irq` failing to rise within the latency, or staying high one cycle after `rd_ack`.

// File: rtl/cmd_nibble_port.sv
module cmd_nibble_port #(
  parameter int READY_LAT = 3,
  parameter int EXT_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] port_sel,
  input  logic       wr_stb,
  input  logic       rd_ack,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       ready,
  output logic       data_irq
);
  localparam int CW = $clog2(READY_LAT + 1);
  localparam int EXT_AW = (EXT_DEPTH > 1) ? $clog2(EXT_DEPTH) : 1;
  localparam logic [5:0] A_EXT_LO = 6'h3A;
  localparam logic [5:0] A_EXT_HI = 6'h3B;
  localparam logic [5:0] A_EXT_DAT = 6'h3C;
  localparam logic [16:0] EXT_LIM = 17'(EXT_DEPTH);

  logic [7:0] regs [64];
  logic [7:0] ext_mem [EXT_DEPTH];
  logic [CW-1:0] busy_cnt;
  logic rd_pend, have_addr, have_hi;
  logic [5:0] addr_q;
  logic [3:0] hi_nib;
  logic [7:0] rd_q, rd_val;

  wire accept = wr_stb && (port_sel == 3'b100) && ready;
  wire [15:0] ext_addr = {regs[A_EXT_HI], regs[A_EXT_LO]};
  wire ext_hit = {1'b0, ext_addr} < EXT_LIM;
  wire [EXT_AW-1:0] ext_idx = ext_addr[EXT_AW-1:0];
  wire [7:0] ext_rd = ext_hit ? ext_mem[ext_idx] : 8'h00;
  wire wr_fire = accept && !din[7] && have_addr && have_hi;
  wire [7:0] wr_byte = {hi_nib, din[3:0]};

  assign ready = (busy_cnt == '0) && !rd_pend;
  assign data_irq = rd_pend && (busy_cnt == '0);
  assign dout = data_irq ? rd_q : 8'h00;

  always_comb rd_val = (din[5:0] == A_EXT_DAT) ? ext_rd : regs[din[5:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      rd_pend <= 1'b0;
      have_addr <= 1'b0;
      have_hi <= 1'b0;
      addr_q <= '0;
      hi_nib <= '0;
      rd_q <= '0;
      for (int i = 0; i < 64; i++) regs[i] <= 8'h00;
      for (int i = 0; i < EXT_DEPTH; i++) ext_mem[i] <= 8'h00;
    end else begin
      if (accept) busy_cnt <= CW'(READY_LAT);
      else if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
      if (data_irq && rd_ack) rd_pend <= 1'b0;
      if (accept) begin
        if (din[7]) begin
          have_hi <= 1'b0;
          if (din[6]) begin
            rd_pend <= 1'b1;
            rd_q <= rd_val;
            have_addr <= 1'b0;
          end else begin
            have_addr <= 1'b1;
            addr_q <= din[5:0];
          end
        end else if (have_addr) begin
          if (!have_hi) begin
            hi_nib <= din[3:0];
            have_hi <= 1'b1;
          end else begin
            have_hi <= 1'b0;
          end
        end
      end
      if (wr_fire) begin
        if (addr_q == A_EXT_DAT) begin
          if (ext_hit) ext_mem[ext_idx] <= wr_byte;
        end else begin
          regs[addr_q] <= wr_byte;
        end
      end
    end
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready); // R5
  AST_IRQ_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    data_irq |-> !ready); // R6
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_irq && !rd_ack) |=> (data_irq && $stable(dout))); // R6
  AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_irq && rd_ack) |=> !data_irq); // R6
  AST_NIBBLE_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    have_hi |-> have_addr); // R8
  AST_UNSEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !accept && !rd_pend) |=> ready); // R1
endmodule

// File: tb/cmd_nibble_port_tb.sv
module cmd_nibble_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] port_sel = 3'b000;
  logic wr_stb = 1'b0, rd_ack = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic ready, data_irq;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_nibble_port #(.READY_LAT(LAT), .EXT_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_stb(wr_stb),
    .rd_ack(rd_ack), .din(din), .dout(dout), .ready(ready), .data_irq(data_irq));

  localparam logic [13:0] VEC [6] = '{
    {6'h01, 8'hB0}, {6'h02, 8'h5A}, {6'h10, 8'hFF},
    {6'h2F, 8'h01}, {6'h3F, 8'hC3}, {6'h00, 8'h7E}};

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int g = 0; g < 1000 && !ready; g++) @(negedge clk);
    port_sel = 3'b100; din = b; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; port_sel = 3'b000;
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [7:0] v);
    send_byte({2'b10, a});
    send_byte({4'h7, v[7:4]});   // R3: bits 6:4 set, must be ignored
    send_byte({4'h0, v[3:0]});
  endtask

  task automatic rd_reg(input logic [5:0] a, input logic [7:0] exp, input string tag);
    send_byte({2'b11, a});
    for (int g = 0; g < 1000 && !data_irq; g++) @(negedge clk);
    chk(tag, dout, exp);
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
    chk({tag, " irq cleared R6"}, {7'd0, data_irq}, 8'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lowc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 ready", {7'd0, ready}, 8'd1);
    chk("R11 irq", {7'd0, data_irq}, 8'd0);
    chk("R11 dout", dout, 8'h00);
    rd_reg(6'h15, 8'h00, "R11 reg reset");

    // R8: data bytes with nothing armed after reset
    send_byte(8'h0F); send_byte(8'h0F);
    rd_reg(6'h00, 8'h00, "R8 after reset");

    // Table walk: R2 R3 writes then reads
    foreach (VEC[i]) wr_reg(VEC[i][13:8], VEC[i][7:0]);
    foreach (VEC[i]) rd_reg(VEC[i][13:8], VEC[i][7:0], "R2 R3 table");

    // R5 ready low length
    send_byte(8'h81);
    lowc = 1;
    for (int g = 0; g < 100 && !ready; g++) begin @(negedge clk); if (!ready) lowc++; end
    chk("R5 ready low cycles", 8'(lowc), 8'(LAT));

    // R1 unselected strobe ignored (reg 0x01 armed above)
    port_sel = 3'b010; din = 8'h0C; wr_stb = 1'b1;
    @(negedge clk);
    chk("R1 ready unchanged", {7'd0, ready}, 8'd1);
    din = 8'h0D; @(negedge clk);
    wr_stb = 1'b0; port_sel = 3'b000;
    rd_reg(6'h01, 8'hB0, "R1 reg unchanged");

    // R6 irq holds until ack
    send_byte(8'hC2);
    repeat (LAT + 4) @(negedge clk);
    chk("R6 irq held", {7'd0, data_irq}, 8'd1);
    chk("R6 ready low while pending", {7'd0, ready}, 8'd0);
    chk("R6 dout held", dout, 8'h5A);
    rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0;
    chk("R6 irq after ack", {7'd0, data_irq}, 8'd0);
    chk("R6 dout quiet", dout, 8'h00);

    // R4 abort on new address
    send_byte(8'h85); send_byte(8'h0F);
    send_byte(8'h86); send_byte(8'h03); send_byte(8'h0C);
    rd_reg(6'h05, 8'h00, "R4 aborted reg");
    rd_reg(6'h06, 8'h3C, "R4 new reg");

    // R7 address stays armed
    send_byte(8'hB0);
    send_byte(8'h01); send_byte(8'h02);
    send_byte(8'h0A); send_byte(8'h0B);
    rd_reg(6'h30, 8'hAB, "R7 last pair");

    // R8 data bytes after a read request
    wr_reg(6'h07, 8'h11);
    rd_reg(6'h07, 8'h11, "R8 setup");
    send_byte(8'h0F); send_byte(8'h0F);
    rd_reg(6'h07, 8'h11, "R8 after read");

    // R9 extended window
    wr_reg(6'h3A, 8'h05); wr_reg(6'h3B, 8'h00); wr_reg(6'h3C, 8'hA7);
    wr_reg(6'h3A, 8'h06); wr_reg(6'h3C, 8'h3D);
    rd_reg(6'h3C, 8'h3D, "R9 ext 0x0006");
    wr_reg(6'h3A, 8'h05);
    rd_reg(6'h3C, 8'hA7, "R9 ext 0x0005");
    rd_reg(6'h3A, 8'h05, "R9 low addr readback");

    // R10 out of range
    wr_reg(6'h3B, 8'h01); wr_reg(6'h3C, 8'h55);
    rd_reg(6'h3C, 8'h00, "R10 out of range read");
    wr_reg(6'h3B, 8'h00);
    rd_reg(6'h3C, 8'hA7, "R10 no alias write");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule